// File: doc/BRIEF.md
# Reservation Station Wakeup and Select

This block is the scheduling window of an out-of-order core. Each entry holds one instruction waiting to execute: two source operand tags, each with its own readiness tracking, a destination tag and the execution latency of that instruction. One new instruction can be written into a free entry per cycle. Each cycle the select logic looks at the entries whose two sources are both ready and issues up to `IW` of them, oldest first by allocation order. Issued entries are freed at the end of that cycle.

Wakeup happens at select time, not at completion. The destination tags of the instructions issued in a cycle go to every waiting source in the window, where they are compared against the stored tags. On a match, the source does not become ready at once. It loads a countdown with the producer's latency and becomes ready exactly when the producer's result can be bypassed. A dependent of a one-cycle producer can therefore issue in the very next cycle. A flush empties the window.

Each source operand is a small state machine with four states. `SRC_EMPTY` means the entry is unused. `SRC_WAIT` means the producer has not issued. `SRC_COUNT` means the producer has issued and the latency is counting down. `SRC_READY` means the operand is available. Transitions:
- *load-ready*: EMPTY to READY.
- *load-wait*: EMPTY to WAIT.
- *load-hit*: EMPTY to COUNT or READY, when allocation meets a same-cycle broadcast.
- *hit*: WAIT to COUNT, or WAIT to READY for a one-cycle producer.
- *expire*: COUNT to READY when the count reaches 1.
- *release*: READY to EMPTY on issue.
- *flush*: any state to EMPTY.

Top module: `rs_wakeup_select`

## Requirements
- R1: After reset, or after a flush, no issue is reported and `rs_full` is low. An allocation presented in the same cycle as `flush` is ignored and never issues.
- R2: An entry allocated in cycle t with both sources marked ready issues in cycle t+1, provided no older ready entries fill the `IW` issue slots.
- R3: At most `IW` (2) entries issue per cycle. When more are ready, the ones allocated earliest issue first, independent of which slot they occupy.
- R4: Every allocated entry issues exactly once. Its slot is then free.
- R5: A waiting source whose tag equals a destination tag issued in cycle p, with latency code c (latency = c+1, codes 0..3 meaning 1..4 cycles), lets its entry issue no earlier than cycle p+c+1. With no other limit, the entry issues in exactly that cycle.
- R6: An entry with two waiting sources issues in the later of the two cycles that R5 gives for its sources.
- R7: An entry allocated in the same cycle that its source's producer issues catches that broadcast, with the same timing as R5.
- R8: When all 16 entries are occupied, `rs_full` is high and an allocation request is ignored: that instruction never issues.
- R9: `flush` clears all entries. Issue outputs are forced low during the flush cycle. A flushed entry never issues, even if its producer is later broadcast.
- R10: A broadcast tag that differs from a waiting source's tag does not wake that source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the window; suppresses issue and allocation this cycle |
| alloc_valid | input | 1 | Write a new instruction into a free entry |
| alloc_src0_tag | input | TAG_W | First source operand tag |
| alloc_src0_rdy | input | 1 | First source already available |
| alloc_src1_tag | input | TAG_W | Second source operand tag |
| alloc_src1_rdy | input | 1 | Second source already available |
| alloc_dst_tag | input | TAG_W | Destination tag, broadcast when the entry issues |
| alloc_lat | input | LAT_W | Latency code, latency = code + 1 cycles |
| rs_full | output | 1 | All entries occupied |
| issue_valid | output | IW | Issue slot k carries an instruction this cycle |
| issue_dst | output | IW*TAG_W | Destination tags of issued instructions, slot k at bits k*TAG_W |
| issue_lat | output | IW*LAT_W | Latency codes of issued instructions |

## Verification
Two functions can fall in the same cycle: allocating a new entry, and broadcasting the tag that entry waits for. The bench provokes this by allocating a consumer in the cycle right after its producer is allocated, which is the producer's issue cycle. It then checks that the consumer issues exactly latency cycles after the producer, for every latency code. The same sweep is repeated with the consumer allocated well before its producer, so the in-window wakeup path is compared against the allocation-time path. Flush colliding with a pending issue, and allocation colliding with flush, are judged by the tag never appearing on the issue outputs.

// File: rtl/rs_pkg.sv
package rs_pkg;
    typedef enum logic [1:0] {
        SRC_EMPTY = 2'd0,
        SRC_WAIT  = 2'd1,
        SRC_COUNT = 2'd2,
        SRC_READY = 2'd3
    } src_state_e;
endpackage

// File: rtl/rs_src_op.sv
module rs_src_op
    import rs_pkg::*;
#(
    parameter int TAG_W = 6,
    parameter int LAT_W = 2,
    parameter int IW    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic                load,
    input  logic [TAG_W-1:0]    load_tag,
    input  logic                load_rdy,
    input  logic                release_i,
    input  logic [IW-1:0]       bc_valid,
    input  logic [IW*TAG_W-1:0] bc_tag,
    input  logic [IW*LAT_W-1:0] bc_lat,
    output logic                rdy_o
);
    src_state_e       state_q, state_n;
    logic [TAG_W-1:0] tag_q, tag_n, cmp_tag;
    logic [LAT_W-1:0] cnt_q, cnt_n, hit_lat;
    logic             hit;

    // IW associative comparators against this operand's tag
    always_comb begin
        cmp_tag = load ? load_tag : tag_q;
        hit     = 1'b0;
        hit_lat = '0;
        for (int k = 0; k < IW; k++) begin
            if (bc_valid[k] && (bc_tag[k*TAG_W +: TAG_W] == cmp_tag)) begin
                hit     = 1'b1;
                hit_lat = bc_lat[k*LAT_W +: LAT_W];
            end
        end
    end

    always_comb begin
        state_n = state_q;
        tag_n   = tag_q;
        cnt_n   = cnt_q;
        if (flush) begin
            state_n = SRC_EMPTY;
        end else begin
            unique case (state_q)
                SRC_EMPTY: begin
                    if (load) begin
                        tag_n = load_tag;
                        if (load_rdy) begin
                            state_n = SRC_READY;
                        end else if (hit) begin
                            state_n = (hit_lat == '0) ? SRC_READY : SRC_COUNT;
                            cnt_n   = hit_lat;
                        end else begin
                            state_n = SRC_WAIT;
                        end
                    end
                end
                SRC_WAIT: begin
                    if (hit) begin
                        state_n = (hit_lat == '0) ? SRC_READY : SRC_COUNT;
                        cnt_n   = hit_lat;
                    end
                end
                SRC_COUNT: begin
                    if (cnt_q == LAT_W'(1)) state_n = SRC_READY;
                    else                    cnt_n   = cnt_q - 1'b1;
                end
                SRC_READY: begin
                    if (release_i) state_n = SRC_EMPTY;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SRC_EMPTY;
            tag_q   <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            tag_q   <= tag_n;
            cnt_q   <= cnt_n;
        end
    end

    always_comb rdy_o = (state_q == SRC_READY);

    p_count_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SRC_COUNT) |-> (cnt_q != '0));
    p_count_steps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SRC_COUNT && cnt_q > LAT_W'(1) && !flush)
        |=> (state_q == SRC_COUNT && cnt_q == $past(cnt_q) - 1'b1));
    p_release_only_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        release_i |-> (state_q == SRC_READY));
    p_load_into_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (state_q == SRC_EMPTY));
endmodule

// File: rtl/rs_age_select.sv
module rs_age_select #(
    parameter int N  = 16,
    parameter int IW = 2,
    localparam int IDX_W = $clog2(N)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                alloc_en,
    input  logic [IDX_W-1:0]    alloc_slot,
    input  logic [N-1:0]        req,
    output logic [N-1:0]        gnt_vec,
    output logic [IW-1:0]       pick_valid,
    output logic [IW*IDX_W-1:0] pick_idx
);
    // older_q[i][j] set: entry i was allocated before entry j
    logic [N-1:0] older_q [N];
    logic [N-1:0] avail;
    logic         blocked;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) older_q[i] <= '0;
        end else if (alloc_en) begin
            for (int j = 0; j < N; j++) begin
                if (IDX_W'(j) == alloc_slot) older_q[j] <= '0;
                else                         older_q[j][alloc_slot] <= 1'b1;
            end
        end
    end

    always_comb begin
        avail      = req;
        gnt_vec    = '0;
        pick_valid = '0;
        pick_idx   = '0;
        blocked    = 1'b0;
        for (int p = 0; p < IW; p++) begin
            for (int i = 0; i < N; i++) begin
                if (avail[i] && !pick_valid[p]) begin
                    blocked = 1'b0;
                    for (int j = 0; j < N; j++)
                        if (avail[j] && older_q[j][i]) blocked = 1'b1;
                    if (!blocked) begin
                        pick_valid[p]                 = 1'b1;
                        pick_idx[p*IDX_W +: IDX_W]    = IDX_W'(i);
                    end
                end
            end
            if (pick_valid[p]) begin
                avail[pick_idx[p*IDX_W +: IDX_W]]   = 1'b0;
                gnt_vec[pick_idx[p*IDX_W +: IDX_W]] = 1'b1;
            end
        end
    end

    p_grant_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gnt_vec) == $countones(pick_valid));
    p_grant_subset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_vec & ~req) == '0);

    for (genvar p = 1; p < IW; p++) begin : g_order_chk
        p_slots_packed_r3: assert property (@(posedge clk) disable iff (!rst_n)
            pick_valid[p] |-> pick_valid[p-1]);
        p_older_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
            pick_valid[p] |-> older_q[pick_idx[(p-1)*IDX_W +: IDX_W]][pick_idx[p*IDX_W +: IDX_W]]);
    end
endmodule

// File: rtl/rs_wakeup_select.sv
module rs_wakeup_select #(
    parameter int N     = 16,
    parameter int IW    = 2,
    parameter int TAG_W = 6,
    parameter int LAT_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic                alloc_valid,
    input  logic [TAG_W-1:0]    alloc_src0_tag,
    input  logic                alloc_src0_rdy,
    input  logic [TAG_W-1:0]    alloc_src1_tag,
    input  logic                alloc_src1_rdy,
    input  logic [TAG_W-1:0]    alloc_dst_tag,
    input  logic [LAT_W-1:0]    alloc_lat,
    output logic                rs_full,
    output logic [IW-1:0]       issue_valid,
    output logic [IW*TAG_W-1:0] issue_dst,
    output logic [IW*LAT_W-1:0] issue_lat
);
    localparam int IDX_W = $clog2(N);

    logic [N-1:0]       valid_q, rdy0, rdy1, req, gnt_vec, release_v, load_v;
    logic [TAG_W-1:0]   dst_q [N];
    logic [LAT_W-1:0]   lat_q [N];
    logic [IDX_W-1:0]   alloc_slot;
    logic               alloc_go;
    logic [IW-1:0]      pick_valid;
    logic [IW*IDX_W-1:0] pick_idx;

    // lowest free slot
    always_comb begin
        alloc_slot = '0;
        for (int i = N-1; i >= 0; i--)
            if (!valid_q[i]) alloc_slot = IDX_W'(i);
    end

    assign rs_full  = &valid_q;
    assign alloc_go = alloc_valid && !rs_full && !flush;
    assign req      = valid_q & rdy0 & rdy1;

    rs_age_select #(.N(N), .IW(IW)) u_age (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_en   (alloc_go),
        .alloc_slot (alloc_slot),
        .req        (req),
        .gnt_vec    (gnt_vec),
        .pick_valid (pick_valid),
        .pick_idx   (pick_idx)
    );

    always_comb begin
        issue_valid = pick_valid & {IW{~flush}};
        for (int k = 0; k < IW; k++) begin
            issue_dst[k*TAG_W +: TAG_W] = dst_q[pick_idx[k*IDX_W +: IDX_W]];
            issue_lat[k*LAT_W +: LAT_W] = lat_q[pick_idx[k*IDX_W +: IDX_W]];
        end
    end

    assign release_v = gnt_vec & {N{~flush}};

    always_ff @(posedge clk) begin
        if (!rst_n || flush) valid_q <= '0;
        else                 valid_q <= (valid_q & ~release_v) | load_v;
    end

    for (genvar i = 0; i < N; i++) begin : g_entry
        assign load_v[i] = alloc_go && (alloc_slot == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dst_q[i] <= '0;
                lat_q[i] <= '0;
            end else if (load_v[i]) begin
                dst_q[i] <= alloc_dst_tag;
                lat_q[i] <= alloc_lat;
            end
        end

        rs_src_op #(.TAG_W(TAG_W), .LAT_W(LAT_W), .IW(IW)) u_src0 (
            .clk (clk), .rst_n (rst_n), .flush (flush),
            .load (load_v[i]), .load_tag (alloc_src0_tag), .load_rdy (alloc_src0_rdy),
            .release_i (release_v[i]),
            .bc_valid (issue_valid), .bc_tag (issue_dst), .bc_lat (issue_lat),
            .rdy_o (rdy0[i])
        );
        rs_src_op #(.TAG_W(TAG_W), .LAT_W(LAT_W), .IW(IW)) u_src1 (
            .clk (clk), .rst_n (rst_n), .flush (flush),
            .load (load_v[i]), .load_tag (alloc_src1_tag), .load_rdy (alloc_src1_rdy),
            .release_i (release_v[i]),
            .bc_valid (issue_valid), .bc_tag (issue_dst), .bc_lat (issue_lat),
            .rdy_o (rdy1[i])
        );
    end

    p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0));
    p_flush_mutes_issue_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (issue_valid == '0));
    p_full_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_full && !flush && issue_valid == '0) |=> rs_full);
    p_alloc_flush_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && alloc_valid) |=> !rs_full);

    for (genvar k = 0; k < IW; k++) begin : g_issue_chk
        p_issue_from_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
            issue_valid[k] |-> valid_q[pick_idx[k*IDX_W +: IDX_W]]);
    end
endmodule

// File: tb/rs_wakeup_select_tb.sv
module rs_wakeup_select_tb_top;
    localparam int N = 16, IW = 2, TW = 6, LW = 2;

    logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
    logic a_valid = 1'b0, a_r0 = 1'b0, a_r1 = 1'b0;
    logic [TW-1:0] a_s0 = '0, a_s1 = '0, a_dst = '0;
    logic [LW-1:0] a_lat = '0;
    logic rs_full;
    logic [IW-1:0] issue_valid;
    logic [IW*TW-1:0] issue_dst;
    logic [IW*LW-1:0] issue_lat;

    int cyc = 0, tests = 0, fails = 0;
    int icnt [64];
    int icyc [64];
    bit done = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rs_wakeup_select #(.N(N), .IW(IW), .TAG_W(TW), .LAT_W(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .alloc_valid(a_valid), .alloc_src0_tag(a_s0), .alloc_src0_rdy(a_r0),
        .alloc_src1_tag(a_s1), .alloc_src1_rdy(a_r1), .alloc_dst_tag(a_dst),
        .alloc_lat(a_lat), .rs_full(rs_full), .issue_valid(issue_valid),
        .issue_dst(issue_dst), .issue_lat(issue_lat)
    );

    // issue log, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            for (int k = 0; k < IW; k++) begin
                if (issue_valid[k]) begin
                    icnt[issue_dst[k*TW +: TW]] = icnt[issue_dst[k*TW +: TW]] + 1;
                    icyc[issue_dst[k*TW +: TW]] = cyc;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_log();
        for (int i = 0; i < 64; i++) begin
            icnt[i] = 0;
            icyc[i] = -1;
        end
    endtask

    task automatic alloc(input int s0, input bit r0, input int s1, input bit r1,
                         input int dst, input int lat);
        a_valid = 1'b1;
        a_s0 = TW'(s0); a_r0 = r0; a_s1 = TW'(s1); a_r1 = r1;
        a_dst = TW'(dst); a_lat = LW'(lat);
        tick();
        a_valid = 1'b0;
    endtask

    task automatic do_flush();
        flush = 1'b1;
        tick();
        flush = 1'b0;
    endtask

    initial begin
        int t0, tp, ta, tb, e, sum;
        clear_log();
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1: reset state
        for (int i = 0; i < 3; i++) begin
            check(issue_valid == '0, "R1 issue after reset", int'(issue_valid), 0);
            check(!rs_full, "R1 full after reset", int'(rs_full), 0);
            tick();
        end

        // R5/R7/R2/R4: producer then consumer in its issue cycle
        for (int pc = 0; pc < 4; pc++) begin
            clear_log();
            t0 = cyc;
            alloc(0, 1, 0, 1, 1, pc);
            alloc(1, 0, 0, 1, 2, 0);
            repeat (8) tick();
            check(icyc[1] == t0 + 1, "R2 producer issue cycle", icyc[1], t0 + 1);
            check(icyc[2] == t0 + pc + 2, "R7 same-cycle wakeup", icyc[2], t0 + pc + 2);
            check(icnt[1] == 1 && icnt[2] == 1, "R4 issued once", icnt[1] + icnt[2], 2);
        end

        // R5: consumer waits in window before producer arrives
        for (int pc = 0; pc < 4; pc++) begin
            clear_log();
            alloc(9, 0, 0, 1, 4, 1);
            tick(); tick();
            tp = cyc;
            alloc(0, 1, 0, 1, 9, pc);
            repeat (8) tick();
            check(icyc[4] == tp + pc + 2, "R5 countdown wakeup", icyc[4], tp + pc + 2);
            check(icnt[4] == 1, "R4 consumer once", icnt[4], 1);
        end

        // R6: two producers, all latency pairs
        for (int la = 0; la < 4; la++) begin
            for (int lb = 0; lb < 4; lb++) begin
                clear_log();
                alloc(3, 0, 4, 0, 5, 0);
                ta = cyc;
                alloc(0, 1, 0, 1, 3, la);
                tb = cyc;
                alloc(0, 1, 0, 1, 4, lb);
                repeat (9) tick();
                e = (ta + la + 2 > tb + lb + 2) ? ta + la + 2 : tb + lb + 2;
                check(icyc[5] == e, "R6 later source wins", icyc[5], e);
            end
        end

        // R3: oldest first, two per cycle, age independent of slot
        clear_log();
        t0 = cyc;
        alloc(0, 1, 0, 1, 20, 0);
        alloc(30, 0, 0, 1, 21, 0);
        alloc(30, 0, 0, 1, 22, 0);
        alloc(30, 0, 30, 0, 23, 0);
        alloc(0, 1, 30, 0, 24, 0);
        alloc(0, 1, 0, 1, 30, 0);
        repeat (6) tick();
        check(icyc[21] == t0 + 7, "R3 oldest pair first", icyc[21], t0 + 7);
        check(icyc[22] == t0 + 7, "R3 second slot", icyc[22], t0 + 7);
        check(icyc[23] == t0 + 8, "R3 younger deferred", icyc[23], t0 + 8);
        check(icyc[24] == t0 + 8, "R3 youngest deferred", icyc[24], t0 + 8);

        // R10: mismatched tag does not wake
        clear_log();
        alloc(5, 0, 0, 1, 7, 0);
        alloc(0, 1, 0, 1, 6, 0);
        repeat (6) tick();
        check(icnt[6] == 1, "R10 other producer issued", icnt[6], 1);
        check(icnt[7] == 0, "R10 no false wakeup", icnt[7], 0);
        tp = cyc;
        alloc(0, 1, 0, 1, 5, 0);
        repeat (5) tick();
        check(icyc[7] == tp + 2, "R10 true match wakes", icyc[7], tp + 2);

        // R8: full window ignores allocation
        clear_log();
        for (int i = 0; i < N; i++) alloc(63, 0, 63, 0, 32 + i, 0);
        check(rs_full, "R8 full flag", int'(rs_full), 1);
        alloc(0, 1, 0, 1, 48, 0);
        repeat (3) tick();
        check(icnt[48] == 0, "R8 dropped alloc", icnt[48], 0);
        check(rs_full, "R8 still full", int'(rs_full), 1);

        // R9: flush clears; flushed waiters never wake
        do_flush();
        check(!rs_full, "R9 empty after flush", int'(rs_full), 0);
        check(issue_valid == '0, "R1 no issue after flush", int'(issue_valid), 0);
        alloc(0, 1, 0, 1, 63, 0);
        repeat (4) tick();
        sum = 0;
        for (int i = 32; i < 48; i++) sum += icnt[i];
        check(icnt[63] == 1, "R9 producer after flush", icnt[63], 1);
        check(sum == 0, "R9 flushed entries silent", sum, 0);

        // R9: flush in the cycle an entry would issue
        clear_log();
        alloc(0, 1, 0, 1, 49, 0);
        do_flush();
        repeat (3) tick();
        check(icnt[49] == 0, "R9 flush beats issue", icnt[49], 0);

        // R1: allocation during flush is ignored
        clear_log();
        flush = 1'b1;
        alloc(0, 1, 0, 1, 50, 0);
        flush = 1'b0;
        repeat (3) tick();
        check(icnt[50] == 0, "R1 alloc under flush", icnt[50], 0);
        check(!rs_full, "R1 window empty", int'(rs_full), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule